// File: doc/BRIEF.md
# Multiplicative Convergence Fixed-Point Divider

This block divides an unsigned integer numerator by an unsigned integer denominator and returns an unsigned fixed-point quotient with `W` integer bits and `F` fraction bits. No quotient bit is resolved on its own. The denominator is first shifted left until its top bit is set, so that it reads as a fraction in [0.5, 1). The numerator gets the same shift, which keeps the ratio unchanged. Each pass then forms the correction factor `2 - t` and scales both the running numerator `x` and the running denominator `t` by it. The distance of `t` from one is squared on every pass, so the count of correct quotient bits roughly doubles with each pass. When `t` has settled at one, `x` holds the quotient.

A single multiplier does both updates, with the `x` product in one cycle and the `t` product in the next, under a small state machine. Every product is truncated back to the internal fraction width. The caller picks the number of passes per operation. A zero denominator skips the passes and returns the largest quotient code.

Operands enter on a valid/ready handshake. An operation is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, and the operand pins are ignored at all other times. The result is offered with `out_valid` and holds steady until a clock edge sees `out_ready` high. Only after that edge does the block become idle again.

Top module: `cdiv_top`

## Requirements
- R1: `in_ready` is high exactly when no operation is in progress or waiting to be delivered. While an operation is in progress or its result is waiting, `in_valid` and the operand pins have no effect on the result or on the timing.
- R2: Once `out_valid` is high, it and `out_quot` stay unchanged until a clock edge with `out_ready` high. After that edge `out_valid` is low and `in_ready` is high.
- R3: Suppose an operation is accepted at clock edge k with a nonzero denominator and an iteration count n ≥ 1. Then `out_valid` first goes high just after edge k + 2n. If n = 0 or the denominator is zero, it goes high just after edge k.
- R4: For a nonzero denominator D, numerator N and an iteration count of at least 5 (default widths W=16, F=8), `out_quot` read as an unsigned integer lies within 2 of floor(N·256/D).
- R5: A zero denominator gives `out_quot` with every bit set (2^24 − 1 at default widths), whatever the numerator and the iteration count.
- R6: With an iteration count of 0 and a nonzero denominator, `out_quot` equals floor(N·256/P) exactly, where P is the smallest power of two strictly greater than D.
- R7: A zero numerator with a nonzero denominator gives `out_quot` = 0 for any iteration count.
- R8: For fixed operands, the quotient never decreases as the iteration count grows. Inside the loop the running denominator stays in [0.5, 1) and the running numerator never decreases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands presented |
| in_ready | output | 1 | Block idle and able to take operands |
| in_num | input | W | Unsigned numerator |
| in_den | input | W | Unsigned denominator |
| in_iters | input | IW | Number of convergence passes |
| out_valid | output | 1 | Quotient available |
| out_ready | input | 1 | Consumer takes the quotient |
| out_quot | output | W+F | Unsigned quotient, F fraction bits |

## Verification
The assertions assume that the caller holds the operands steady only for the accepting edge and drives `out_ready` freely. They also assume that, at default widths, the iteration count never exceeds the 4-bit range. The loop invariants on `t` and `x` rest on normalization, which leaves the shifted denominator with its top bit set for every nonzero input. Random operands and iteration counts come from a fixed-seed generator. Zero, one, all-ones and power-of-two operands are added as directed cases. The bench also drives garbage operands with `in_valid` high while the block is busy, and it stalls `out_ready` for random stretches.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MULX = 2'd1,
    ST_MULT = 2'd2,
    ST_DONE = 2'd3
  } cdiv_state_e;
endpackage

// File: rtl/cdiv_lzc.sv
// Leading-zero count of a W-bit value; zero flag when no bit is set.
module cdiv_lzc #(
  parameter int W = 16,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  output logic [SW-1:0] lz,
  output logic          all_zero
);
  always_comb begin
    logic found;
    found = 1'b0;
    lz    = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && val[i]) begin
        lz    = SW'(W - 1 - i);
        found = 1'b1;
      end
    end
    all_zero = ~found;
  end
endmodule

// File: rtl/cdiv_norm.sv
// Shifts the denominator so its top bit is set and gives the numerator the same shift.
// Both results are placed on a grid with FB fraction bits.
module cdiv_norm #(
  parameter int W  = 16,
  parameter int FB = 28,
  localparam int XW = W + FB,
  localparam int TW = FB + 2,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  num,
  input  logic [W-1:0]  den,
  output logic [XW-1:0] x0,
  output logic [TW-1:0] t0,
  output logic          den_zero
);
  logic [SW-1:0] lz;
  logic [W-1:0]  den_sh;

  cdiv_lzc #(.W(W)) u_lzc (
    .val      (den),
    .lz       (lz),
    .all_zero (den_zero)
  );

  always_comb begin
    den_sh = den << lz;
    t0     = {2'b00, den_sh, {(FB - W){1'b0}}};
    x0     = XW'(num) << (32'(lz) + (FB - W));
  end
endmodule

// File: rtl/cdiv_mul.sv
// One shared multiplier: forms f = 2 - t and scales x or t by it, then truncates.
module cdiv_mul #(
  parameter int W  = 16,
  parameter int FB = 28,
  localparam int XW = W + FB,
  localparam int TW = FB + 2,
  localparam int PW = XW + TW
) (
  input  logic          sel_t,
  input  logic [XW-1:0] x,
  input  logic [TW-1:0] t,
  output logic [XW-1:0] x_next,
  output logic [TW-1:0] t_next
);
  localparam logic [TW-1:0] TWO = TW'(1) << (FB + 1);

  logic [TW-1:0] fac;
  logic [XW-1:0] opa;
  logic [PW-1:0] prod;

  always_comb begin
    fac    = TWO - t;
    opa    = sel_t ? XW'(t) : x;
    prod   = PW'(opa) * PW'(fac);
    x_next = prod[FB +: XW];
    t_next = prod[FB +: TW];
  end
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top #(
  parameter int W  = 16,
  parameter int F  = 8,
  parameter int IW = 4,
  localparam int FB = W + F + 4,
  localparam int XW = W + FB,
  localparam int TW = FB + 2,
  localparam int QW = W + F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_num,
  input  logic [W-1:0]  in_den,
  input  logic [IW-1:0] in_iters,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [QW-1:0] out_quot
);
  import cdiv_pkg::*;

  cdiv_state_e   state;
  logic [XW-1:0] x_q, x0, x_next;
  logic [TW-1:0] t_q, t0, t_next;
  logic [IW-1:0] cnt_q;
  logic          sat_q, den_zero, accept;

  cdiv_norm #(.W(W), .FB(FB)) u_norm (
    .num      (in_num),
    .den      (in_den),
    .x0       (x0),
    .t0       (t0),
    .den_zero (den_zero)
  );

  cdiv_mul #(.W(W), .FB(FB)) u_mul (
    .sel_t  (state == ST_MULT),
    .x      (x_q),
    .t      (t_q),
    .x_next (x_next),
    .t_next (t_next)
  );

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign accept    = in_valid && in_ready;
  assign out_quot  = sat_q ? {QW{1'b1}} : x_q[FB - F +: QW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      x_q   <= '0;
      t_q   <= '0;
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          x_q   <= x0;
          t_q   <= t0;
          cnt_q <= in_iters;
          sat_q <= den_zero;
          state <= (den_zero || in_iters == '0) ? ST_DONE : ST_MULX;
        end
        ST_MULX: begin
          x_q   <= x_next;
          state <= ST_MULT;
        end
        ST_MULT: begin
          t_q   <= t_next;
          cnt_q <= cnt_q - 1'b1;
          state <= (cnt_q == IW'(1)) ? ST_DONE : ST_MULX;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: never offering to take operands while a result is pending
  assert_ready_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  // R2: result held under back-pressure
  assert_hold_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_quot)));

  // R2: delivery frees the block
  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

  // R3: nonzero work starts the loop on the next cycle
  assert_loop_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_den != '0 && in_iters != '0) |=> (!out_valid && !in_ready));

  // R5: zero denominator finishes at once with saturated code
  assert_zero_den_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_den == '0) |=> (out_valid && (&out_quot)));

  // R8: running denominator stays in [0.5, 1)
  assert_t_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MULX || state == ST_MULT) |-> (t_q[TW-1:FB] == 2'b00 && t_q[FB-1]));

  // R8: running numerator never shrinks
  assert_x_grow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MULT) |-> (x_q >= $past(x_q)));
endmodule

// File: tb/sim_cdiv_top.sv
module sim_cdiv_top;
  localparam int W = 16, F = 8, IW = 4, QW = W + F;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0]  in_num = '0, in_den = '0;
  logic [IW-1:0] in_iters = '0;
  logic          in_ready, out_valid;
  logic [QW-1:0] out_quot;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cdiv_top #(.W(W), .F(F), .IW(IW)) u0 (
    .clk, .rst_n, .in_valid, .in_ready, .in_num, .in_den, .in_iters,
    .out_valid, .out_ready, .out_quot
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exact_q(input longint n, input longint d);
    return (n << F) / d;
  endfunction

  function automatic longint pow2_q(input longint n, input longint d);
    int p = 0;
    for (int i = 0; i < W; i++) if (d[i]) p = i;
    return (n << F) >> (p + 1);
  endfunction

  task automatic run_op(input logic [W-1:0] n, input logic [W-1:0] d,
                        input logic [IW-1:0] it, output longint q);
    int lat, hold;
    longint q0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_num = n; in_den = d; in_iters = it;
    @(posedge clk);
    @(negedge clk);
    // R1: garbage operands while busy must be ignored
    in_num = W'($urandom); in_den = W'($urandom); in_iters = IW'($urandom);
    lat = 0;
    while (!out_valid && lat < 100) begin
      check(!in_ready, "R1 ready while busy", in_ready, 0);
      @(negedge clk);
      lat++;
    end
    check(lat == ((d == 0 || it == 0) ? 0 : 2 * int'(it)), "R3 latency", lat,
          (d == 0 || it == 0) ? 0 : 2 * int'(it));
    q = out_quot;
    hold = $urandom_range(0, 3);
    repeat (hold) begin
      q0 = out_quot;
      @(negedge clk);
      check(out_valid && out_quot == q0, "R2 hold", out_quot, q0);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R2 release", {out_valid, in_ready}, 1);
  endtask

  task automatic check_acc(input logic [W-1:0] n, input logic [W-1:0] d, input logic [IW-1:0] it);
    longint q, e, diff;
    run_op(n, d, it, q);
    e = exact_q(n, d);
    diff = q - e;
    check(diff <= 2 && diff >= -2, "R4 accuracy", q, e);
  endtask

  initial begin
    longint q, qprev;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!out_valid && !in_ready == 1'b0 || 1'b0, "R1 reset state", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid, "R1 idle after reset", in_ready, 1);

    // R5: zero denominator
    run_op(16'd1234, 16'd0, 4'd7, q);
    check(q == (1 << QW) - 1, "R5 saturate", q, (1 << QW) - 1);
    run_op(16'd0, 16'd0, 4'd0, q);
    check(q == (1 << QW) - 1, "R5 saturate zero num", q, (1 << QW) - 1);

    // R7: zero numerator
    run_op(16'd0, 16'd77, 4'd6, q);
    check(q == 0, "R7 zero numerator", q, 0);

    // R6: no passes gives power-of-two scaling
    run_op(16'd50000, 16'd300, 4'd0, q);
    check(q == pow2_q(50000, 300), "R6 zero iters", q, pow2_q(50000, 300));
    run_op(16'hFFFF, 16'h8000, 4'd0, q);
    check(q == pow2_q(16'hFFFF, 16'h8000), "R6 zero iters top", q, pow2_q(16'hFFFF, 16'h8000));
    for (int k = 0; k < 10; k++) begin
      logic [W-1:0] n, d;
      n = W'($urandom); d = W'($urandom_range(1, 65535));
      run_op(n, d, 4'd0, q);
      check(q == pow2_q(n, d), "R6 zero iters random", q, pow2_q(n, d));
    end

    // R4: directed corners
    check_acc(16'hFFFF, 16'd1, 4'd5);
    check_acc(16'hFFFF, 16'hFFFF, 4'd5);
    check_acc(16'd1, 16'hFFFF, 4'd6);
    check_acc(16'd1000, 16'd1024, 4'd5);
    check_acc(16'd3, 16'd3, 4'd15);

    // R8: monotone in iteration count
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] n, d;
      n = W'($urandom); d = W'($urandom_range(1, 65535));
      qprev = -1;
      for (int it = 0; it <= 6; it++) begin
        run_op(n, d, IW'(it), q);
        check(q >= qprev, "R8 monotone", q, qprev);
        qprev = q;
      end
    end

    // R4: random operands
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] n, d;
      n = W'($urandom);
      d = (k % 4 == 0) ? W'($urandom_range(1, 255)) : W'($urandom_range(1, 65535));
      check_acc(n, d, IW'($urandom_range(5, 15)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule